// File: doc/BRIEF.md
# Configurable Serial Line Transmitter

This block takes words from a show-ahead FIFO and sends each one as an asynchronous serial character on a single line. The line idles high. Each character has one low start bit, then the data bits with the least significant bit first, then an optional parity bit and a high stop period. The data length, parity rule, stop length and bit-rate divisor are run-time inputs. The block captures them when a character starts, so software may change them at any time.

Flow control is automatic. A character starts only when all three of these hold: the block is idle, the FIFO has data and the active-low clear-to-send input is low. A character that has already started always completes. The block also drives the active-low modem-control outputs and a transceiver shutdown line.

During suspend, the serial outputs are handled in one of two ways. If the strap was high during reset, they are held at their inactive level. If the strap was low during reset, an output-enable port tells the pads to release them.

Top module: `serFrameTx`

## Requirements
- R1: After reset, with suspend low, txd is 1, fifoRd is 0, outEn is 1 and shutdownN is 1.
- R2: A frame starts when the block is idle, fifoEmpty is 0, ctsN is 0 and suspend is 0. In that cycle fifoRd is 1 for exactly one cycle and fifoData is captured at the following clock edge. From the next cycle, txd is 0 for one bit time.
- R3: cfgLen selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8 and 4 gives 16. Codes 5 to 7 give 8. Data bits are sent from bit 0 upward, one bit time each.
- R4: cfgParity selects the parity bit, which follows the last data bit for one bit time. Code 0 sends no parity bit. Code 1 makes the total count of ones odd and code 2 makes it even. Code 3 always sends 1 and code 4 always sends 0. Codes 5 to 7 send no parity bit.
- R5: cfgStop selects the stop period, during which txd is high. Code 0 gives 16 ticks, code 1 gives 24 ticks and code 2 gives 32 ticks. Code 3 gives 16 ticks.
- R6: One tick lasts cfgDiv+1 clocks and one bit time is 16 ticks. So cfgDiv = 0 gives a 16-clock bit time.
- R7: While ctsN is 1, no frame starts and fifoRd stays 0. If ctsN rises during a frame, that frame still completes unchanged.
- R8: cfgLen, cfgParity, cfgStop and cfgDiv are captured when a frame starts. Changing them during the frame does not alter that frame.
- R9: When words are waiting, the next frame's fifoRd occurs in the first cycle after the stop period ends. That leaves exactly one idle high clock between frames.
- R10: While suspend is 1: shutdownN is 0 and no frame starts. If strapHold was 1 during reset, txd, rtsN and dtrN are 1 and outEn is 1.
- R11: If strapHold was 0 during reset, outEn is 0 while suspend is 1. Changing strapHold after reset has no effect.
- R12: While suspend is 0: rtsN equals the inverse of rtsOn, dtrN equals the inverse of dtrOn, outEn is 1 and shutdownN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoData | input | DATA_W | Head word of the show-ahead FIFO |
| fifoEmpty | input | 1 | FIFO holds no word |
| fifoRd | output | 1 | Pop strobe; the head word is taken at this edge |
| cfgLen | input | 3 | Data length code |
| cfgParity | input | 3 | Parity rule code |
| cfgStop | input | 2 | Stop length code |
| cfgDiv | input | DIV_W | Tick divisor; a tick lasts cfgDiv+1 clocks |
| rtsOn | input | 1 | Request-to-send control, active high |
| dtrOn | input | 1 | Terminal-ready control, active high |
| ctsN | input | 1 | Clear-to-send, active low |
| suspend | input | 1 | Suspend request |
| strapHold | input | 1 | Strap sampled during reset: 1 holds outputs, 0 releases them |
| txd | output | 1 | Serial data line |
| rtsN | output | 1 | Request-to-send, active low |
| dtrN | output | 1 | Terminal-ready, active low |
| outEn | output | 1 | Pad enable for txd, rtsN and dtrN |
| shutdownN | output | 1 | Transceiver shutdown, active low |

## Verification
A behavioural model in the bench turns each word into a list of expected line levels, one per clock, and compares the line on every cycle. The bench sweeps every length code with a different parity code, stop code and divisor. Asymmetric data words distinguish bit order from length truncation, and mark, space, odd and even parity produce different bits on the same data.

Back-to-back words expose any error in the single idle clock between frames. Deasserting clear-to-send partway through a frame, and changing the configuration partway through a frame, separate the frame-boundary sampling from sampling on every cycle. Two resets with opposite straps, plus a strap change after reset, separate the two suspend behaviours.

// File: rtl/serTxPkg.sv
package serTxPkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int TICK_W        = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  // strobes from control to datapath: at most one per cycle
  typedef struct packed {
    logic load;       // capture word, drive start bit
    logic dataBit;    // drive next data bit
    logic parityBit;  // drive parity bit
    logic stopBit;    // drive stop level
  } txStrobe_t;
endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl
  import serTxPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEmpty,
  input  logic             ctsN,
  input  logic             suspend,
  input  logic [2:0]       cfgLen,
  input  logic [2:0]       cfgParity,
  input  logic [1:0]       cfgStop,
  input  logic [DIV_W-1:0] cfgDiv,
  output logic             fifoRd,
  output txStrobe_t        stb,
  output logic [2:0]       parMode
);
  localparam int LEN_W = $clog2(DATA_W + 1);
  localparam logic [TICK_W-1:0] BIT_TICKS  = TICK_W'(TICKS_PER_BIT);
  localparam logic [TICK_W-1:0] HALF_TICKS = TICK_W'(TICKS_PER_BIT * 3 / 2);
  localparam logic [TICK_W-1:0] TWO_TICKS  = TICK_W'(TICKS_PER_BIT * 2);

  txState_e          state;
  logic [DIV_W-1:0]  divCnt, divLat;
  logic [TICK_W-1:0] tickCnt, stopLat, curTicks;
  logic [LEN_W-1:0]  bitIdx, lenLat;
  logic              parEnLat;
  logic              tick, bitEnd, lastBit, startFrame;

  function automatic logic [LEN_W-1:0] decodeLen(input logic [2:0] code);
    case (code)
      3'd0:    return LEN_W'(5);
      3'd1:    return LEN_W'(6);
      3'd2:    return LEN_W'(7);
      3'd4:    return LEN_W'(DATA_W);
      default: return LEN_W'(8);
    endcase
  endfunction

  function automatic logic [TICK_W-1:0] decodeStop(input logic [1:0] code);
    case (code)
      2'd1:    return HALF_TICKS;
      2'd2:    return TWO_TICKS;
      default: return BIT_TICKS;
    endcase
  endfunction

  assign startFrame = (state == ST_IDLE) && !fifoEmpty && !ctsN && !suspend;
  assign fifoRd     = startFrame;
  assign tick       = (divCnt == divLat);
  assign curTicks   = (state == ST_STOP) ? stopLat : BIT_TICKS;
  assign bitEnd     = (state != ST_IDLE) && tick && (tickCnt == curTicks - TICK_W'(1));
  assign lastBit    = (bitIdx == lenLat - LEN_W'(1));

  // bit timing counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (startFrame) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (state != ST_IDLE) begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (tick) tickCnt <= bitEnd ? '0 : tickCnt + TICK_W'(1);
    end
  end

  // frame sequencing and configuration capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitIdx   <= '0;
      lenLat   <= LEN_W'(8);
      stopLat  <= BIT_TICKS;
      divLat   <= '0;
      parMode  <= '0;
      parEnLat <= 1'b0;
    end else if (startFrame) begin
      state    <= ST_START;
      bitIdx   <= '0;
      lenLat   <= decodeLen(cfgLen);
      stopLat  <= decodeStop(cfgStop);
      divLat   <= cfgDiv;
      parMode  <= cfgParity;
      parEnLat <= (cfgParity >= 3'd1) && (cfgParity <= 3'd4);
    end else if (bitEnd) begin
      case (state)
        ST_START: begin
          state  <= ST_DATA;
          bitIdx <= '0;
        end
        ST_DATA: begin
          if (lastBit) state <= parEnLat ? ST_PARITY : ST_STOP;
          else         bitIdx <= bitIdx + LEN_W'(1);
        end
        ST_PARITY: state <= ST_STOP;
        ST_STOP:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.load      = startFrame;
    stb.dataBit   = bitEnd && ((state == ST_START) || ((state == ST_DATA) && !lastBit));
    stb.parityBit = bitEnd && (state == ST_DATA) && lastBit && parEnLat;
    stb.stopBit   = bitEnd && (((state == ST_DATA) && lastBit && !parEnLat) ||
                               (state == ST_PARITY));
  end
endmodule

// File: rtl/serTxPath.sv
module serTxPath
  import serTxPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [DATA_W-1:0] fifoData,
  input  logic [2:0]        parMode,
  output logic              txdLine
);
  logic [DATA_W-1:0] shiftQ;
  logic              accQ;
  logic              parBit;

  always_comb begin
    case (parMode)
      3'd1:    parBit = ~accQ;  // odd
      3'd2:    parBit = accQ;   // even
      3'd3:    parBit = 1'b1;   // mark
      default: parBit = 1'b0;   // space
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      accQ    <= 1'b0;
      txdLine <= 1'b1;
    end else if (stb.load) begin
      shiftQ  <= fifoData;
      accQ    <= 1'b0;
      txdLine <= 1'b0;
    end else if (stb.dataBit) begin
      txdLine <= shiftQ[0];
      accQ    <= accQ ^ shiftQ[0];
      shiftQ  <= shiftQ >> 1;
    end else if (stb.parityBit) begin
      txdLine <= parBit;
    end else if (stb.stopBit) begin
      txdLine <= 1'b1;
    end
  end
endmodule

// File: rtl/serFrameTx.sv
module serFrameTx
  import serTxPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              fifoRd,
  input  logic [2:0]        cfgLen,
  input  logic [2:0]        cfgParity,
  input  logic [1:0]        cfgStop,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              rtsOn,
  input  logic              dtrOn,
  input  logic              ctsN,
  input  logic              suspend,
  input  logic              strapHold,
  output logic              txd,
  output logic              rtsN,
  output logic              dtrN,
  output logic              outEn,
  output logic              shutdownN
);
  txStrobe_t  ctlStb;
  logic [2:0] parMode;
  logic       txdLine;
  logic       strapQ;

  serTxCtrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .ctsN(ctsN), .suspend(suspend),
    .cfgLen(cfgLen), .cfgParity(cfgParity), .cfgStop(cfgStop), .cfgDiv(cfgDiv),
    .fifoRd(fifoRd), .stb(ctlStb), .parMode(parMode)
  );

  serTxPath #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .fifoData(fifoData),
    .parMode(parMode), .txdLine(txdLine)
  );

  // strap follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) strapQ <= strapHold;
  end

  assign txd       = suspend ? 1'b1 : txdLine;
  assign rtsN      = suspend ? 1'b1 : ~rtsOn;
  assign dtrN      = suspend ? 1'b1 : ~dtrOn;
  assign outEn     = !(suspend && !strapQ);
  assign shutdownN = !suspend;
endmodule

// File: rtl/serTxChecker.sv
module serTxChecker
  import serTxPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      fifoRd,
  input logic      fifoEmpty,
  input logic      ctsN,
  input logic      suspend,
  input logic      txd,
  input logic      rtsN,
  input logic      rtsOn,
  input logic      outEn,
  input logic      shutdownN,
  input txStrobe_t stb
);
  assert_cts_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> (!ctsN && !fifoEmpty));

  assert_single_pop_R2: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> !fifoRd);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> (suspend || !txd));

  assert_suspend_R10: assert property (@(posedge clk) disable iff (!rstN)
    suspend |-> (!shutdownN && !fifoRd));

  assert_awake_R12: assert property (@(posedge clk) disable iff (!rstN)
    !suspend |-> (outEn && shutdownN && (rtsN != rtsOn)));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.dataBit, stb.parityBit, stb.stopBit}));
endmodule

bind serFrameTx serTxChecker u_serTxChecker (
  .clk(clk), .rstN(rstN), .fifoRd(fifoRd), .fifoEmpty(fifoEmpty), .ctsN(ctsN),
  .suspend(suspend), .txd(txd), .rtsN(rtsN), .rtsOn(rtsOn), .outEn(outEn),
  .shutdownN(shutdownN), .stb(ctlStb)
);

// File: tb/test_serFrameTx.sv
module test_serFrameTx;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN = 1'b0;
  logic [DATA_W-1:0] fifoData = '0;
  logic              fifoEmpty = 1'b1;
  logic              fifoRd;
  logic [2:0]        cfgLen = 3'd3;
  logic [2:0]        cfgParity = 3'd0;
  logic [1:0]        cfgStop = 2'd0;
  logic [DIV_W-1:0]  cfgDiv = '0;
  logic              rtsOn = 1'b0, dtrOn = 1'b0, ctsN = 1'b0, suspend = 1'b0;
  logic              strapHold = 1'b1;
  logic              txd, rtsN, dtrN, outEn, shutdownN;

  serFrameTx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_serFrameTx (
    .clk(clk), .rstN(rstN), .fifoData(fifoData), .fifoEmpty(fifoEmpty), .fifoRd(fifoRd),
    .cfgLen(cfgLen), .cfgParity(cfgParity), .cfgStop(cfgStop), .cfgDiv(cfgDiv),
    .rtsOn(rtsOn), .dtrOn(dtrOn), .ctsN(ctsN), .suspend(suspend), .strapHold(strapHold),
    .txd(txd), .rtsN(rtsN), .dtrN(dtrN), .outEn(outEn), .shutdownN(shutdownN)
  );

  int    checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";
  logic [DATA_W-1:0] fifoQ[$];
  logic  expLine[$];
  logic  modelCur = 1'b1, modelIdle = 1'b1, popPending = 1'b0, strapAtReset = 1'b1;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void refreshFifo();
    fifoEmpty = (fifoQ.size() == 0);
    fifoData  = fifoEmpty ? '0 : fifoQ[0];
  endfunction

  task automatic pushWord(input logic [DATA_W-1:0] w);
    fifoQ.push_back(w);
    refreshFifo();
  endtask

  // expected line levels, one per clock, from the requirements (R3-R6)
  function automatic void buildFrame(input logic [DATA_W-1:0] w);
    int per = 16 * (int'(cfgDiv) + 1);
    int n, ones = 0, stopT;
    logic pb;
    bit hasPar = 1'b1;
    case (cfgLen)
      3'd0: n = 5; 3'd1: n = 6; 3'd2: n = 7; 3'd4: n = 16; default: n = 8;
    endcase
    for (int k = 0; k < per; k++) expLine.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      ones += int'(w[i]);
      for (int k = 0; k < per; k++) expLine.push_back(w[i]);
    end
    case (cfgParity)
      3'd1: pb = (ones % 2 == 0);
      3'd2: pb = (ones % 2 == 1);
      3'd3: pb = 1'b1;
      3'd4: pb = 1'b0;
      default: begin pb = 1'b0; hasPar = 1'b0; end
    endcase
    if (hasPar) for (int k = 0; k < per; k++) expLine.push_back(pb);
    case (cfgStop)
      2'd1: stopT = 24; 2'd2: stopT = 32; default: stopT = 16;
    endcase
    for (int k = 0; k < stopT * (int'(cfgDiv) + 1); k++) expLine.push_back(1'b1);
  endfunction

  // per-cycle monitor and reference model
  always begin
    @(negedge clk);
    if (popPending) begin
      void'(fifoQ.pop_front());
      popPending = 1'b0;
      refreshFifo();
    end
    #1;
    if (!rstN) begin
      expLine.delete();
      modelCur  = 1'b1;
      modelIdle = 1'b1;
    end else begin
      logic expRd;
      expRd = modelIdle && !fifoEmpty && !ctsN && !suspend;
      check(curReq, "fifoRd", fifoRd, expRd);
      if (!suspend) begin
        check(curReq, "txd", txd, modelCur);
        check("R12", "rtsN", rtsN, !rtsOn);
        check("R12", "dtrN", dtrN, !dtrOn);
        check("R12", "outEn", outEn, 1'b1);
        check("R12", "shutdownN", shutdownN, 1'b1);
      end else begin
        check("R10", "shutdownN", shutdownN, 1'b0);
        if (strapAtReset) begin
          check("R10", "txd held", txd, 1'b1);
          check("R10", "rtsN held", rtsN, 1'b1);
          check("R10", "dtrN held", dtrN, 1'b1);
          check("R10", "outEn held", outEn, 1'b1);
        end else begin
          check("R11", "outEn released", outEn, 1'b0);
        end
      end
      if (expLine.size() > 0) begin
        modelCur  = expLine.pop_front();
        modelIdle = 1'b0;
      end else if (expRd) begin
        buildFrame(fifoData);
        modelCur   = expLine.pop_front();
        modelIdle  = 1'b0;
        popPending = 1'b1;
      end else begin
        modelCur  = 1'b1;
        modelIdle = 1'b1;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0;
    strapHold = strap;
    strapAtReset = strap;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (fifoQ.size() != 0 || !modelIdle || popPending);
    repeat (3) @(negedge clk);
  endtask

  task automatic setCfg(input logic [2:0] l, input logic [2:0] p, input logic [1:0] s,
                        input int d);
    @(negedge clk);
    cfgLen = l; cfgParity = p; cfgStop = s; cfgDiv = DIV_W'(d);
  endtask

  initial begin
    doReset(1'b1);
    @(negedge clk); #2;
    // R1: reset state
    check("R1", "txd", txd, 1'b1);
    check("R1", "fifoRd", fifoRd, 1'b0);
    check("R1", "outEn", outEn, 1'b1);
    check("R1", "shutdownN", shutdownN, 1'b1);

    // R2, R6, R9: 8-bit, no parity, fastest rate, back-to-back words
    curReq = "R9";
    setCfg(3'd3, 3'd0, 2'd0, 0);
    @(negedge clk); pushWord(16'h00A5); pushWord(16'h003C);
    waitIdle();
    check("R2", "words consumed", fifoQ.size(), 0);

    // R3, R4, R5, R6: sweep length codes with varied parity, stop and divisor
    curReq = "R3";
    for (int c = 0; c < 8; c++) begin
      setCfg(3'(c), 3'(c), 2'(c % 4), c % 3);
      @(negedge clk); pushWord(16'hB38D ^ 16'(c * 16'h1111)); pushWord(16'h4E21);
      waitIdle();
    end
    curReq = "R4";
    for (int p = 0; p < 5; p++) begin
      setCfg(3'd3, 3'(p), 2'd1, 1);
      @(negedge clk); pushWord(16'h0017); pushWord(16'h0080);
      waitIdle();
    end

    // R7: ctsN rises mid-frame; frame completes, next word waits
    curReq = "R7";
    rtsOn = 1'b1;
    setCfg(3'd3, 3'd2, 2'd0, 0);
    @(negedge clk); pushWord(16'h00C3); pushWord(16'h005A);
    repeat (40) @(negedge clk);
    ctsN = 1'b1;
    repeat (300) @(negedge clk);
    #2;
    check("R7", "word held while ctsN high", fifoQ.size(), 1);
    @(negedge clk); ctsN = 1'b0;
    waitIdle();

    // R8: configuration changed during a frame
    curReq = "R8";
    dtrOn = 1'b1;
    setCfg(3'd3, 3'd2, 2'd0, 1);
    @(negedge clk); pushWord(16'hF00F);
    repeat (50) @(negedge clk);
    cfgLen = 3'd4; cfgParity = 3'd1; cfgStop = 2'd2; cfgDiv = DIV_W'(2);
    repeat (200) @(negedge clk);
    cfgLen = 3'd3; cfgParity = 3'd2; cfgStop = 2'd0; cfgDiv = DIV_W'(1);
    waitIdle();

    // R10: suspend with hold strap; nothing starts
    curReq = "R10";
    @(negedge clk); suspend = 1'b1; pushWord(16'h0099);
    repeat (60) @(negedge clk);
    #2;
    check("R10", "no frame during suspend", fifoQ.size(), 1);
    @(negedge clk); suspend = 1'b0;
    waitIdle();

    // R11: release strap, then strap pin changed after reset
    curReq = "R11";
    doReset(1'b0);
    repeat (3) @(negedge clk);
    suspend = 1'b1;
    repeat (10) @(negedge clk);
    strapHold = 1'b1;
    repeat (10) @(negedge clk);
    #2;
    check("R11", "outEn after strap pin change", outEn, 1'b0);
    @(negedge clk); suspend = 1'b0;
    @(negedge clk); pushWord(16'h0055);
    waitIdle();

    summary();
  end
endmodule